// File: doc/BRIEF.md
# I2C Checksummed Register Transaction Master

This block carries out whole register transactions with an I2C target that uses 15-bit register numbers and 16-bit data words. Every transaction is protected by an 8-bit checksum. A single-cycle command gives the operation (read or write), a 7-bit device address, the register number and, for a write, the data word. The block then steps through the byte-level operations of the transaction. It issues each one to an external byte/bit engine that owns all SCL/SDA timing. It checks every acknowledge and finally reports a status together with the read word.

The checksum is the bitwise inverse of an 8-bit one's-complement sum, with the carry wrapped around. The block computes it over the register bytes, and for writes over the data bytes as well. The upper register byte holds register bits 14:8 in its bits 7:1, and its bit 0 flags the direction. If a transmitted byte is not acknowledged, or the engine reports a bit-level error, the attempt is abandoned and a bus-clear operation is requested. Reads are retried a bounded number of times. Each read attempt is wrapped in an access-grant handshake, and a refused grant ends the command with a distinct status. Writes get a single attempt and use no grant.

The checksum byte received during a read is returned as it arrived. A flag beside it tells whether it matches the checksum recomputed over the two received data bytes. This flag has no influence on retries.

Top module: `i2cx_master`

## Requirements
- R1: A command is accepted when `cmd_valid_i` is high and `busy_o` is low. `busy_o` is high from the next cycle until the cycle in which `done_o` is high. Commands presented while busy are ignored and have no effect on the running transaction or on any later one.
- R2: A read issues these engine operations in order: START(0), TX address byte {dev,0}, TX register-high, TX register-low, TX checksum, START(0), TX address byte {dev,1}, RX(3), RX, RX, STOP(1). The op codes are START=0, STOP=1, TX=2, RX=3 and CLEAR=4.
- R3: A write issues START, TX {dev,0}, TX register-high, TX register-low, TX data[15:8], TX data[7:0], TX checksum, STOP.
- R4: The register-high byte holds register bits 14:8 in its bits 7:1. Its bit 0 is 1 for a read and 0 for a write. The address byte holds the device address in its bits 7:1 and the direction in bit 0.
- R5: The transmitted checksum is the inverse of the one's-complement (end-around carry) sum of register-high and register-low. For a write the sum also includes data-high and data-low.
- R6: On every RX operation `op_mack_o` is 0: an acknowledge after the two data bytes, and the same level for the final phase bit after the checksum byte.
- R7: A TX operation that completes with `op_nack_i`, or any operation that completes with `op_err_i`, ends the attempt with a CLEAR(4) operation. A read is attempted at most 10 times. After 10 failed attempts the status is I2C error (1).
- R8: A write is attempted once. One failure gives one CLEAR and status I2C error (1), and no grant is requested.
- R9: Each read attempt raises `arb_req_o` and waits for `arb_resp_i`. The request is dropped between attempts and after the command ends. A refusal (`arb_ok_i`=0) ends the command with status sync error (2) and starts no bus operation.
- R10: On success (status 0) `rdata_o` is {first received byte, second received byte}. `rx_csum_o` is the third received byte. `csum_ok_o` is 1 exactly when that byte equals the inverted one's-complement sum of the two data bytes, and it never changes the status.
- R11: `done_o` is a one-cycle pulse, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_dev_i | input | 7 | Target device address |
| cmd_reg_i | input | 15 | Register number |
| cmd_wdata_i | input | 16 | Write data word |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 I2C error, 2 sync error |
| rdata_o | output | 16 | Read word |
| rx_csum_o | output | 8 | Received checksum byte |
| csum_ok_o | output | 1 | Received checksum matches recomputed value |
| arb_req_o | output | 1 | Access grant request (level) |
| arb_resp_i | input | 1 | Grant answer strobe |
| arb_ok_i | input | 1 | Grant answer: 1 granted, 0 refused |
| op_valid_o | output | 1 | Engine operation pending |
| op_code_o | output | 3 | Engine operation code |
| op_byte_o | output | 8 | Byte to transmit |
| op_mack_o | output | 1 | Bit the master drives after an RX byte |
| op_done_i | input | 1 | Engine operation finished |
| op_err_i | input | 1 | Bit-level error on finished operation |
| op_nack_i | input | 1 | Transmitted byte not acknowledged |
| op_rdata_i | input | 8 | Received byte |

## Verification
The embedded assertions check several properties on every cycle. A pending engine operation holds steady until the engine finishes it. The latched command stays frozen while busy. `done_o` is a pulse with `busy_o` low, the attempt counter never passes its limit, a refused grant ends the command at once with sync status, and a failed write ends after a single bus clear. Other behaviours can only be shown by the bench's scenarios against its own model. These are the exact byte sequences and checksum values, the retry counts with their number of CLEAR operations and grant requests, the assembly of the read word and the checksum match flag, and the fact that a command presented mid-transaction is ignored.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_STOP  = 3'd1,
    OP_TX    = 3'd2,
    OP_RX    = 3'd3,
    OP_CLEAR = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_I2C_ERR  = 2'd1,
    ST_SYNC_ERR = 2'd2
  } stat_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ARB, S_RUN, S_CLR, S_GAP
  } fsm_e;
endpackage

// File: rtl/i2cx_csum.sv
module i2cx_csum #(
  parameter int N_BYTES = 4
) (
  input  logic [N_BYTES*8-1:0] bytes_i,
  output logic [7:0]           csum_o
);
  logic [N_BYTES:0][7:0] acc;
  assign acc[0] = 8'h00;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_add
    logic [8:0] s;
    assign s          = {1'b0, acc[i]} + {1'b0, bytes_i[i*8 +: 8]};
    // end-around carry; cannot overflow since s <= 0x1FE
    assign acc[i+1]   = s[7:0] + {7'd0, s[8]};
  end

  assign csum_o = ~acc[N_BYTES];
endmodule

// File: rtl/i2cx_seq.sv
module i2cx_seq
  import i2cx_pkg::*;
#(
  parameter bit FINAL_ACK_BIT = 1'b0
) (
  input  logic [3:0]  step_i,
  input  logic        wr_i,
  input  logic [6:0]  dev_i,
  input  logic [14:0] reg_i,
  input  logic [15:0] wdata_i,
  input  logic [7:0]  csum_i,
  output op_e         code_o,
  output logic [7:0]  byte_o,
  output logic        mack_o,
  output logic        last_o
);
  logic [7:0] reg_hi;
  assign reg_hi = {reg_i[14:8], ~wr_i};

  always_comb begin
    code_o = OP_STOP;
    byte_o = 8'h00;
    mack_o = 1'b0;
    last_o = 1'b0;
    if (wr_i) begin
      unique case (step_i)
        4'd0: code_o = OP_START;
        4'd1: begin code_o = OP_TX; byte_o = {dev_i, 1'b0}; end
        4'd2: begin code_o = OP_TX; byte_o = reg_hi; end
        4'd3: begin code_o = OP_TX; byte_o = reg_i[7:0]; end
        4'd4: begin code_o = OP_TX; byte_o = wdata_i[15:8]; end
        4'd5: begin code_o = OP_TX; byte_o = wdata_i[7:0]; end
        4'd6: begin code_o = OP_TX; byte_o = csum_i; end
        default: begin code_o = OP_STOP; last_o = 1'b1; end
      endcase
    end else begin
      unique case (step_i)
        4'd0: code_o = OP_START;
        4'd1: begin code_o = OP_TX; byte_o = {dev_i, 1'b0}; end
        4'd2: begin code_o = OP_TX; byte_o = reg_hi; end
        4'd3: begin code_o = OP_TX; byte_o = reg_i[7:0]; end
        4'd4: begin code_o = OP_TX; byte_o = csum_i; end
        4'd5: code_o = OP_START;
        4'd6: begin code_o = OP_TX; byte_o = {dev_i, 1'b1}; end
        4'd7: code_o = OP_RX;
        4'd8: code_o = OP_RX;
        4'd9: begin code_o = OP_RX; mack_o = FINAL_ACK_BIT; end
        default: begin code_o = OP_STOP; last_o = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/i2cx_master.sv
module i2cx_master
  import i2cx_pkg::*;
#(
  parameter int RD_TRIES      = 10,
  parameter int WR_TRIES      = 1,
  parameter bit FINAL_ACK_BIT = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic        cmd_write_i,
  input  logic [6:0]  cmd_dev_i,
  input  logic [14:0] cmd_reg_i,
  input  logic [15:0] cmd_wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  status_o,
  output logic [15:0] rdata_o,
  output logic [7:0]  rx_csum_o,
  output logic        csum_ok_o,
  output logic        arb_req_o,
  input  logic        arb_resp_i,
  input  logic        arb_ok_i,
  output logic        op_valid_o,
  output logic [2:0]  op_code_o,
  output logic [7:0]  op_byte_o,
  output logic        op_mack_o,
  input  logic        op_done_i,
  input  logic        op_err_i,
  input  logic        op_nack_i,
  input  logic [7:0]  op_rdata_i
);
  localparam int MAX_TRIES = (RD_TRIES > WR_TRIES) ? RD_TRIES : WR_TRIES;
  localparam int ATT_W     = $clog2(MAX_TRIES + 1);
  localparam logic [ATT_W-1:0] RD_LIM  = ATT_W'(RD_TRIES);
  localparam logic [ATT_W-1:0] WR_LIM  = ATT_W'(WR_TRIES);
  localparam logic [ATT_W-1:0] MAX_LIM = ATT_W'(MAX_TRIES);

  fsm_e             state_q;
  logic [3:0]       step_q;
  logic             wr_q;
  logic [6:0]       dev_q;
  logic [14:0]      reg_q;
  logic [15:0]      wd_q;
  logic [ATT_W-1:0] att_q;
  logic [15:0]      rdata_q;
  logic [7:0]       rxcs_q;
  stat_e            status_q;
  logic             done_q;

  // checksum over the outgoing register/data bytes
  logic [7:0] tx_csum;
  i2cx_csum #(.N_BYTES(4)) u_tx_csum (
    .bytes_i({{reg_q[14:8], ~wr_q}, reg_q[7:0],
              wr_q ? wd_q[15:8] : 8'h00, wr_q ? wd_q[7:0] : 8'h00}),
    .csum_o (tx_csum)
  );

  // checksum recomputed over the received data bytes
  logic [7:0] rx_calc;
  i2cx_csum #(.N_BYTES(2)) u_rx_csum (
    .bytes_i(rdata_q),
    .csum_o (rx_calc)
  );

  op_e  seq_code;
  logic [7:0] seq_byte;
  logic seq_mack, seq_last;
  i2cx_seq #(.FINAL_ACK_BIT(FINAL_ACK_BIT)) u_seq (
    .step_i (step_q),
    .wr_i   (wr_q),
    .dev_i  (dev_q),
    .reg_i  (reg_q),
    .wdata_i(wd_q),
    .csum_i (tx_csum),
    .code_o (seq_code),
    .byte_o (seq_byte),
    .mack_o (seq_mack),
    .last_o (seq_last)
  );

  logic [ATT_W-1:0] att_nxt, lim;
  logic             op_fail;
  assign att_nxt = att_q + 1'b1;
  assign lim     = wr_q ? WR_LIM : RD_LIM;
  assign op_fail = op_err_i || (seq_code == OP_TX && op_nack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      step_q   <= '0;
      wr_q     <= 1'b0;
      dev_q    <= '0;
      reg_q    <= '0;
      wd_q     <= '0;
      att_q    <= '0;
      rdata_q  <= '0;
      rxcs_q   <= '0;
      status_q <= ST_OK;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          wr_q     <= cmd_write_i;
          dev_q    <= cmd_dev_i;
          reg_q    <= cmd_reg_i;
          wd_q     <= cmd_wdata_i;
          att_q    <= '0;
          step_q   <= '0;
          rdata_q  <= '0;
          rxcs_q   <= '0;
          status_q <= ST_OK;
          state_q  <= cmd_write_i ? S_RUN : S_ARB;
        end
        S_ARB: if (arb_resp_i) begin
          if (arb_ok_i) begin
            step_q  <= '0;
            state_q <= S_RUN;
          end else begin
            status_q <= ST_SYNC_ERR;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        S_RUN: if (op_done_i) begin
          if (op_fail) begin
            state_q <= S_CLR;
          end else begin
            if (seq_code == OP_RX) begin
              unique case (step_q)
                4'd7:    rdata_q[15:8] <= op_rdata_i;
                4'd8:    rdata_q[7:0]  <= op_rdata_i;
                default: rxcs_q        <= op_rdata_i;
              endcase
            end
            if (seq_last) begin
              status_q <= ST_OK;
              done_q   <= 1'b1;
              state_q  <= S_IDLE;
            end else begin
              step_q <= step_q + 4'd1;
            end
          end
        end
        S_CLR: if (op_done_i) begin
          att_q <= att_nxt;
          if (att_nxt < lim) begin
            step_q  <= '0;
            state_q <= wr_q ? S_RUN : S_GAP;
          end else begin
            status_q <= ST_I2C_ERR;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        // one cycle with the grant released before asking again
        S_GAP: state_q <= S_ARB;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign rdata_o    = rdata_q;
  assign rx_csum_o  = rxcs_q;
  assign csum_ok_o  = (rxcs_q == rx_calc);
  assign arb_req_o  = !wr_q && (state_q == S_ARB || state_q == S_RUN || state_q == S_CLR);
  assign op_valid_o = (state_q == S_RUN || state_q == S_CLR);
  assign op_code_o  = (state_q == S_CLR) ? OP_CLEAR : seq_code;
  assign op_byte_o  = seq_byte;
  assign op_mack_o  = seq_mack;

  // R1
  cmd_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || ($stable(reg_q) && $stable(wr_q) && $stable(dev_q))));

  // R2 R3
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_done_i) |=> (op_valid_o && $stable(op_code_o) && $stable(op_byte_o)));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7
  att_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= MAX_LIM);

  // R9
  refuse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ARB && arb_resp_i && !arb_ok_i) |=> (done_o && status_o == ST_SYNC_ERR));

  // R8
  wr_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CLR && op_done_i && wr_q && att_q == WR_LIM - 1'b1)
      |=> (done_o && status_o == ST_I2C_ERR));
endmodule

// File: tb/i2cx_master_bench.sv
module i2cx_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid_i = 0, cmd_write_i = 0;
  logic [6:0]  cmd_dev_i = '0;
  logic [14:0] cmd_reg_i = '0;
  logic [15:0] cmd_wdata_i = '0;
  logic        busy_o, done_o, csum_ok_o, arb_req_o, op_valid_o, op_mack_o;
  logic [1:0]  status_o;
  logic [15:0] rdata_o;
  logic [7:0]  rx_csum_o, op_byte_o;
  logic [2:0]  op_code_o;
  logic        arb_resp_i = 0, arb_ok_i = 0;
  logic        op_done_i = 0, op_err_i = 0, op_nack_i = 0;
  logic [7:0]  op_rdata_i = '0;

  i2cx_master u_i2cx_master (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i, .cmd_write_i, .cmd_dev_i, .cmd_reg_i, .cmd_wdata_i,
    .busy_o, .done_o, .status_o, .rdata_o, .rx_csum_o, .csum_ok_o,
    .arb_req_o, .arb_resp_i, .arb_ok_i,
    .op_valid_o, .op_code_o, .op_byte_o, .op_mack_o,
    .op_done_i, .op_err_i, .op_nack_i, .op_rdata_i
  );

  int checks = 0, failures = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] oadd(logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  // ---------------- engine and grant model ----------------
  int fail_idx = -1, fails_left = 0, refuse_at = -1;
  logic [7:0] rxb [3];
  int rx_i = 0, att_op = 0, n_clear = 0, n_arb = 0, n_log = 0;
  int log_code [32];
  int log_byte [32];
  int log_ack  [32];
  bit pend = 0, drv = 0, arb_prev = 0, arb_answered = 0;
  int cnt = 0, arb_wait = 0;
  bit cur_err = 0, cur_nack = 0;
  logic [7:0] cur_rd = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      arb_resp_i = 1'b0;
      if (arb_req_o && !arb_prev) begin
        n_arb++;
        arb_wait = $urandom % 3;
        arb_answered = 0;
      end
      if (arb_req_o && !arb_answered) begin
        if (arb_wait == 0) begin
          arb_resp_i = 1'b1;
          arb_ok_i = ((n_arb - 1) != refuse_at);
          arb_answered = 1;
        end else arb_wait--;
      end
      arb_prev = arb_req_o;

      if (drv) begin
        op_done_i = 0; op_err_i = 0; op_nack_i = 0; drv = 0;
      end else if (op_valid_o) begin
        if (!pend) begin
          pend = 1;
          cnt = $urandom % 3;
          cur_err = 0; cur_nack = 0; cur_rd = '0;
          if (op_code_o == 3'd4) begin
            n_clear++; n_log = 0; att_op = 0; rx_i = 0;
          end else begin
            log_code[n_log] = op_code_o;
            log_byte[n_log] = op_byte_o;
            log_ack[n_log]  = op_mack_o;
            n_log++;
            if (fails_left > 0 && att_op == fail_idx) begin
              fails_left--;
              if (op_code_o == 3'd2) cur_nack = 1; else cur_err = 1;
            end
            if (op_code_o == 3'd3) begin
              cur_rd = rxb[rx_i % 3];
              rx_i++;
            end
            att_op++;
          end
        end
        if (cnt == 0) begin
          op_done_i = 1; op_err_i = cur_err; op_nack_i = cur_nack; op_rdata_i = cur_rd;
          pend = 0; drv = 1;
        end else cnt--;
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- expected sequence ----------------
  int exp_code [16];
  int exp_byte [16];
  int exp_n;

  task automatic build_exp(bit wr, logic [6:0] dv, logic [14:0] rg, logic [15:0] wd);
    logic [7:0] rh, cs;
    rh = {rg[14:8], ~wr};
    cs = oadd(rh, rg[7:0]);
    if (wr) cs = oadd(oadd(cs, wd[15:8]), wd[7:0]);
    cs = ~cs;
    for (int i = 0; i < 16; i++) begin exp_code[i] = 2; exp_byte[i] = 0; end
    exp_code[0] = 0; exp_byte[1] = {dv, 1'b0}; exp_byte[2] = rh; exp_byte[3] = rg[7:0];
    if (wr) begin
      exp_byte[4] = wd[15:8]; exp_byte[5] = wd[7:0]; exp_byte[6] = cs;
      exp_code[7] = 1; exp_n = 8;
    end else begin
      exp_byte[4] = cs; exp_code[5] = 0; exp_byte[6] = {dv, 1'b1};
      exp_code[7] = 3; exp_code[8] = 3; exp_code[9] = 3; exp_code[10] = 1; exp_n = 11;
    end
  endtask

  // ---------------- one transaction ----------------
  task automatic run_xact(bit wr, logic [6:0] dv, logic [14:0] rg, logic [15:0] wd,
                          logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                          int fails, int fidx, int refuse, bit inject_busy);
    int e_stat, e_arb, e_clr, a_max, mism, nack_cnt;
    logic [7:0] rcs;
    rxb[0] = b0; rxb[1] = b1; rxb[2] = b2;
    fails_left = fails; fail_idx = fidx; refuse_at = refuse;
    n_clear = 0; n_arb = 0; n_log = 0; att_op = 0; rx_i = 0;
    build_exp(wr, dv, rg, wd);
    if (wr) begin
      e_arb = 0;
      e_clr = (fails > 0) ? 1 : 0;
      e_stat = (fails > 0) ? 1 : 0;
    end else begin
      a_max = (fails < 9) ? fails : 9;
      if (refuse >= 0 && refuse <= a_max) begin
        e_stat = 2; e_arb = refuse + 1; e_clr = refuse;
      end else if (fails >= 10) begin
        e_stat = 1; e_arb = 10; e_clr = 10;
      end else begin
        e_stat = 0; e_arb = fails + 1; e_clr = fails;
      end
    end

    @(negedge clk);
    cmd_valid_i = 1; cmd_write_i = wr; cmd_dev_i = dv; cmd_reg_i = rg; cmd_wdata_i = wd;
    @(negedge clk);
    cmd_valid_i = 0;
    chk(busy_o == 1'b1, "R1", "busy after accept", busy_o, 1);
    if (inject_busy) begin
      repeat (3) @(negedge clk);
      cmd_valid_i = 1; cmd_write_i = ~wr; cmd_reg_i = ~rg; cmd_dev_i = ~dv;
      @(negedge clk);
      cmd_valid_i = 0;
    end
    while (!done_o) @(negedge clk);
    chk(busy_o == 1'b0, "R11", "busy low with done", busy_o, 0);
    chk(status_o == e_stat[1:0], wr ? "R8" : "R7 R9", "status", status_o, e_stat);
    chk(n_arb == e_arb, "R9", "grant requests", n_arb, e_arb);
    chk(n_clear == e_clr, "R7", "clear ops", n_clear, e_clr);
    if (e_stat == 0) begin
      mism = 0; nack_cnt = 0;
      for (int i = 0; i < n_log && i < 16; i++) begin
        if (log_code[i] != exp_code[i]) mism++;
        if (exp_code[i] == 2 && log_byte[i] != exp_byte[i]) mism++;
        if (log_code[i] == 3) begin
          nack_cnt++;
          if (log_ack[i] != 0) mism += 100;
        end
      end
      chk(mism == 0 && n_log == exp_n, wr ? "R3" : "R2", "op sequence mismatches", mism, 0);
      chk(log_byte[1] == exp_byte[1] && log_byte[2] == exp_byte[2], "R4",
          "addr/reg-high", {log_byte[1][7:0], log_byte[2][7:0]}, {exp_byte[1][7:0], exp_byte[2][7:0]});
      chk(log_byte[wr ? 6 : 4] == exp_byte[wr ? 6 : 4], "R5", "tx checksum",
          log_byte[wr ? 6 : 4], exp_byte[wr ? 6 : 4]);
      if (!wr) begin
        chk(nack_cnt == 3 && mism < 100, "R6", "rx ack bits", mism, 0);
        rcs = ~oadd(b0, b1);
        chk(rdata_o == {b0, b1}, "R10", "rdata", rdata_o, {b0, b1});
        chk(rx_csum_o == b2, "R10", "rx csum", rx_csum_o, b2);
        chk(csum_ok_o == (b2 == rcs), "R10", "csum ok flag", csum_ok_o, (b2 == rcs));
      end
    end
    if (e_stat == 2) chk(n_log == 0 || e_clr > 0, "R9", "no op after refusal", n_log, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R11", "done pulse width", done_o, 0);
    if (inject_busy) begin
      repeat (4) begin
        chk(busy_o == 1'b0, "R1", "ignored cmd started", busy_o, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    logic [7:0] b0, b1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && op_valid_o == 0 && arb_req_o == 0, "R1",
        "reset outputs", {busy_o, done_o, op_valid_o, arb_req_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // directed corners
    run_xact(0, 7'h7F, 15'h7FFF, 16'h0, 8'hFF, 8'hFF, ~oadd(8'hFF, 8'hFF), 0, -1, -1, 0);
    run_xact(0, 7'h00, 15'h0000, 16'h0, 8'h00, 8'h00, 8'hFF, 0, -1, -1, 0);
    run_xact(1, 7'h50, 15'h0000, 16'h0000, 0, 0, 0, 0, -1, -1, 0);
    run_xact(1, 7'h2A, 15'h7FFF, 16'hFFFF, 0, 0, 0, 0, -1, -1, 0);
    run_xact(0, 7'h11, 15'h1234, 16'h0, 8'hAB, 8'hCD, 8'h00, 0, -1, -1, 0);   // bad rx csum
    run_xact(0, 7'h22, 15'h0456, 16'h0, 8'h12, 8'h34, 8'h99, 3, 2, -1, 0);    // nack retries
    run_xact(0, 7'h22, 15'h0456, 16'h0, 8'h12, 8'h34, 8'h99, 2, 8, -1, 0);    // rx error retries
    run_xact(0, 7'h33, 15'h0100, 16'h0, 8'h01, 8'h02, 8'h03, 9, 4, -1, 0);    // last attempt ok
    run_xact(0, 7'h33, 15'h0100, 16'h0, 8'h01, 8'h02, 8'h03, 10, 1, -1, 0);   // exhausted
    run_xact(1, 7'h44, 15'h2222, 16'hBEEF, 0, 0, 0, 1, 3, -1, 0);             // write fail once
    run_xact(0, 7'h55, 15'h3333, 16'h0, 8'h10, 8'h20, 8'h30, 0, -1, 0, 0);    // refused
    run_xact(0, 7'h55, 15'h3333, 16'h0, 8'h10, 8'h20, 8'h30, 5, 6, 2, 0);     // refused on retry
    run_xact(1, 7'h66, 15'h0F0F, 16'h5A5A, 0, 0, 0, 0, -1, -1, 1);            // busy ignore
    run_xact(0, 7'h67, 15'h7001, 16'h0, 8'hFE, 8'h02, ~oadd(8'hFE, 8'h02), 0, -1, -1, 1);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      bit wr;
      int fails, refuse;
      wr = $urandom % 2;
      b0 = 8'($urandom); b1 = 8'($urandom);
      fails = ($urandom % 4 == 0) ? int'($urandom % (wr ? 2 : 11)) : 0;
      refuse = ($urandom % 8 == 0) ? int'($urandom % 4) : -1;
      run_xact(wr, 7'($urandom), 15'($urandom), 16'($urandom), b0, b1,
               ($urandom % 2) ? ~oadd(b0, b1) : 8'($urandom),
               fails, int'($urandom % (wr ? 8 : 11)), refuse, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule